// File: doc/BRIEF.md
# Oversampled Serial Receiver with Stop-Bit Check

This block receives asynchronous serial frames on a single line and delivers the payload to a parallel register. A frame is one low start bit, then the data bits with the least significant bit first, then a stop bit. An optional ninth data bit follows the eight-bit byte. The ninth bit goes to its own output register.

Timing comes from a strobe that pulses sixteen times per bit period. Each bit is resolved by a majority vote over three samples taken around the bit centre. The receiver raises a completion flag when a frame has been received. When the stop-bit check is switched on, it also keeps a sticky error flag that records any frame whose stop bit was received low. Turning the check on also moves the completion point from the last data bit to the stop bit. The surrounding logic clears both flags with single-cycle clear inputs.

Top module: `uart_frame_rx`

## Requirements
- R1: The serial input passes through SYNC_STAGES (default 2) flip-flops before use. The receiver leaves idle on a high-to-low transition of the synchronized line, provided it is idle and enabled. The oversample counter starts at 0 on that clock, and the first strobe after it takes sample 0.
- R2: Each bit is resolved at the strobe that takes sample OVERSAMPLE/2+1 (sample 9 by default). The result is the majority of the line values at samples 7, 8 and 9, so a single disturbed sample does not change the received bit.
- R3: If the start bit resolves to 1, it is a false start. The receiver returns to idle and does not touch any output.
- R4: Data bits arrive least significant first. With `nine_bit`=0 a frame carries 8 data bits, and received bit i appears on `rx_data[i]`.
- R5: With `nine_bit`=1 a ninth bit follows the byte and is stored on `rx_bit9`. Frames received with `nine_bit`=0 leave `rx_bit9` unchanged.
- R6: With `chk_en`=0, `rx_done` is set and the outputs are loaded at the resolving strobe of the last data bit. `rx_ferr` is never set, whatever the value of the stop bit.
- R7: With `chk_en`=1, `rx_done` is set and the outputs are loaded at the resolving strobe of the stop bit. If that stop bit resolves to 0, `rx_ferr` is set at the same clock.
- R8: `rx_ferr` stays set through later frames that have valid stop bits. Only `clr_fe` or reset clears it.
- R9: `rx_done` stays set until `clr_done` is applied. On a clock where a completion and `clr_done` coincide, the completion wins.
- R10: While `rx_en` is 0 the receiver is held idle, a frame in progress is dropped, no start is detected, and the flags and data keep their values.
- R11: After reset `rx_data`, `rx_bit9`, `rx_done` and `rx_ferr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Oversampling strobe, OVERSAMPLE pulses per bit |
| rx_en | input | 1 | Receive enable |
| nine_bit | input | 1 | 1: frame carries a ninth data bit |
| chk_en | input | 1 | 1: stop-bit check on, completion at stop bit |
| clr_done | input | 1 | Clears the completion flag |
| clr_fe | input | 1 | Clears the framing-error flag |
| rx_data | output | DATA_BITS | Received byte |
| rx_bit9 | output | 1 | Received ninth bit |
| rx_done | output | 1 | Frame-complete flag |
| rx_ferr | output | 1 | Sticky framing-error flag |

## Verification
The bench builds the block with OVERSAMPLE=16, DATA_BITS=8, SYNC_STAGES=2 and MAJORITY=1. It drives one strobe every four clocks, so one bit spans 64 clocks. The phase between the falling start edge and the strobe grid is therefore unknown, and it shifts from frame to frame. A four-clock disturbance of the line covers exactly one strobe. This lets the bench exercise majority voting inside a data bit and rejection of a false start. A behavioural model compares all four outputs on every clock, which pins down the shift of the completion point when the check is switched on.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_e;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o,
   output logic fall_o
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   initial begin
      AST_SYNC_DEPTH : assert (STAGES >= 2)
         else $error("rx_line_sync: STAGES must be at least 2"); // R1
   end

   // chain resets to the idle (high) line level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], line_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign line_o = chain_q[STAGES-1];
   assign fall_o = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/rx_bit_voter.sv
module rx_bit_voter #(
   parameter int OVERSAMPLE = 16,
   parameter bit MAJORITY   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic run_i,
   input  logic line_i,
   output logic dec_o,
   output logic bit_o
);

   localparam int CW = $clog2(OVERSAMPLE);
   localparam logic [CW-1:0] K_EARLY = CW'(OVERSAMPLE/2 - 1);
   localparam logic [CW-1:0] K_MID   = CW'(OVERSAMPLE/2);
   localparam logic [CW-1:0] K_LATE  = CW'(OVERSAMPLE/2 + 1);
   localparam logic [CW-1:0] K_WRAP  = CW'(OVERSAMPLE - 1);

   logic [CW-1:0] cnt_q;
   logic          early_q;
   logic          mid_q;

   initial begin
      AST_OVS_RANGE : assert (OVERSAMPLE >= 4 && (OVERSAMPLE & (OVERSAMPLE - 1)) == 0)
         else $error("rx_bit_voter: OVERSAMPLE must be a power of two, at least 4"); // R2
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         early_q <= 1'b1;
         mid_q   <= 1'b1;
      end else if (!run_i) begin
         cnt_q   <= '0;
      end else if (tick_i) begin
         if (cnt_q == K_EARLY) early_q <= line_i;
         if (cnt_q == K_MID)   mid_q   <= line_i;
         cnt_q <= (cnt_q == K_WRAP) ? '0 : cnt_q + 1'b1;
      end
   end

   assign dec_o = run_i & tick_i & (cnt_q == K_LATE);

   generate
      if (MAJORITY) begin : g_vote3
         assign bit_o = (early_q & mid_q) | (early_q & line_i) | (mid_q & line_i);
      end else begin : g_centre
         logic unused_samples;
         assign unused_samples = early_q ^ line_i;
         assign bit_o = mid_q;
      end
   endgenerate

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
   import uart_rx_pkg::*;
#(
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_en_i,
   input  logic                 nine_bit_i,
   input  logic                 chk_en_i,
   input  logic                 clr_done_i,
   input  logic                 clr_fe_i,
   input  logic                 fall_i,
   input  logic                 dec_i,
   input  logic                 bit_i,
   output logic                 run_o,
   output logic [DATA_BITS-1:0] data_o,
   output logic                 bit9_o,
   output logic                 done_o,
   output logic                 fe_o
);

   localparam int IW = $clog2(DATA_BITS + 1);

   rx_state_e            state_q, state_nx;
   logic [IW-1:0]        idx_q;
   logic [IW-1:0]        last_idx;
   logic [DATA_BITS:0]   sh_q, sh_nx, load_val;
   logic [DATA_BITS-1:0] data_q;
   logic                 bit9_q, done_q, fe_q;
   logic                 load, set_fe;

   initial begin
      AST_DATA_WIDTH : assert (DATA_BITS >= 2)
         else $error("rx_frame_ctrl: DATA_BITS must be at least 2"); // R4
   end

   assign last_idx = nine_bit_i ? IW'(DATA_BITS) : IW'(DATA_BITS - 1);

   always_comb begin
      sh_nx        = sh_q;
      sh_nx[idx_q] = bit_i;
      load_val     = (state_q == ST_DATA) ? sh_nx : sh_q;
   end

   always_comb begin
      state_nx = state_q;
      load     = 1'b0;
      set_fe   = 1'b0;
      case (state_q)
         ST_IDLE:  if (fall_i) state_nx = ST_START;
         ST_START: if (dec_i) state_nx = bit_i ? ST_IDLE : ST_DATA;
         ST_DATA:  if (dec_i && idx_q == last_idx) begin
                      state_nx = ST_STOP;
                      load     = ~chk_en_i;
                   end
         ST_STOP:  if (dec_i) begin
                      state_nx = ST_IDLE;
                      load     = chk_en_i;
                      set_fe   = chk_en_i & ~bit_i;
                   end
         default:  state_nx = ST_IDLE;
      endcase
      if (!rx_en_i) begin
         state_nx = ST_IDLE;
         load     = 1'b0;
         set_fe   = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         sh_q    <= '0;
         data_q  <= '0;
         bit9_q  <= 1'b0;
         done_q  <= 1'b0;
         fe_q    <= 1'b0;
      end else begin
         state_q <= state_nx;
         if (state_q != ST_DATA) begin
            idx_q <= '0;
         end else if (dec_i) begin
            sh_q <= sh_nx;
            if (idx_q != last_idx) idx_q <= idx_q + 1'b1;
         end
         if (load) begin
            data_q <= load_val[DATA_BITS-1:0];
            if (nine_bit_i) bit9_q <= load_val[DATA_BITS];
         end
         if (load)            done_q <= 1'b1;
         else if (clr_done_i) done_q <= 1'b0;
         if (set_fe)          fe_q <= 1'b1;
         else if (clr_fe_i)   fe_q <= 1'b0;
      end
   end

   assign run_o  = (state_q != ST_IDLE);
   assign data_o = data_q;
   assign bit9_o = bit9_q;
   assign done_o = done_q;
   assign fe_o   = fe_q;

   AST_FE_STICKY : assert property (@(posedge clk) disable iff (!rst_n)
      (fe_q && !clr_fe_i) |=> fe_q); // R8
   AST_DONE_HOLDS : assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !clr_done_i) |=> done_q); // R9
   AST_FE_NEEDS_CHECK : assert property (@(posedge clk) disable iff (!rst_n)
      (!fe_q && !chk_en_i) |=> !fe_q); // R6
   AST_DISABLE_IDLES : assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en_i) |=> (state_q == ST_IDLE)); // R10
   AST_FALSE_START : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_START && dec_i && bit_i) |=> (state_q == ST_IDLE)); // R3

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
   parameter int OVERSAMPLE  = 16,
   parameter int DATA_BITS   = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MAJORITY    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_line,
   input  logic                 os_tick,
   input  logic                 rx_en,
   input  logic                 nine_bit,
   input  logic                 chk_en,
   input  logic                 clr_done,
   input  logic                 clr_fe,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_bit9,
   output logic                 rx_done,
   output logic                 rx_ferr
);

   logic line_s, fall_s, run_s, dec_s, bit_s;

   rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (rx_line),
      .line_o (line_s),
      .fall_o (fall_s)
   );

   rx_bit_voter #(.OVERSAMPLE(OVERSAMPLE), .MAJORITY(MAJORITY)) i_voter (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (os_tick),
      .run_i  (run_s),
      .line_i (line_s),
      .dec_o  (dec_s),
      .bit_o  (bit_s)
   );

   rx_frame_ctrl #(.DATA_BITS(DATA_BITS)) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_en_i    (rx_en),
      .nine_bit_i (nine_bit),
      .chk_en_i   (chk_en),
      .clr_done_i (clr_done),
      .clr_fe_i   (clr_fe),
      .fall_i     (fall_s),
      .dec_i      (dec_s),
      .bit_i      (bit_s),
      .run_o      (run_s),
      .data_o     (rx_data),
      .bit9_o     (rx_bit9),
      .done_o     (rx_done),
      .fe_o       (rx_ferr)
   );

endmodule

// File: tb/test_uart_frame_rx.sv
module test_uart_frame_rx;

   localparam int BITCLK = 64;   // 16 strobes x 4 clocks

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic       os_tick = 1'b0;
   logic       rx_en = 1'b0;
   logic       nine_bit = 1'b0;
   logic       chk_en = 1'b0;
   logic       clr_done = 1'b0;
   logic       clr_fe = 1'b0;
   logic [7:0] rx_data;
   logic       rx_bit9, rx_done, rx_ferr;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  ended = 1'b0;

   always #10 clk = ~clk;

   uart_frame_rx i_uart_frame_rx (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
      .rx_en(rx_en), .nine_bit(nine_bit), .chk_en(chk_en),
      .clr_done(clr_done), .clr_fe(clr_fe),
      .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_done(rx_done), .rx_ferr(rx_ferr)
   );

   // ---------------- behavioural reference ----------------
   logic       m_s1, m_line, m_prev, m_busy, m_a, m_b;
   int         m_tno;
   logic [8:0] m_word;
   logic [7:0] e_data;
   logic       e_b9, e_done, e_fe;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 1; m_line = 1; m_prev = 1; m_busy = 0; m_tno = 0;
         m_a = 1; m_b = 1; m_word = '0;
         e_data = '0; e_b9 = 0; e_done = 0; e_fe = 0;
      end else begin
         automatic bit ld = 0;
         automatic bit sf = 0;
         automatic int nb = nine_bit ? 9 : 8;
         automatic bit fall = m_prev && !m_line;
         if (!rx_en) m_busy = 0;
         else if (!m_busy) begin
            if (fall) begin m_busy = 1; m_tno = 0; end
         end else if (os_tick) begin
            automatic int ph = m_tno % 16;
            automatic int bp = m_tno / 16;
            if (ph == 7) m_a = m_line;
            if (ph == 8) m_b = m_line;
            if (ph == 9) begin
               automatic bit v = (int'(m_a) + int'(m_b) + int'(m_line)) >= 2;
               if (bp == 0) begin
                  if (v) m_busy = 0;
               end else if (bp <= nb) begin
                  m_word[bp-1] = v;
                  if (bp == nb && !chk_en) ld = 1;
               end else begin
                  m_busy = 0;
                  if (chk_en) begin ld = 1; sf = !v; end
               end
            end
            m_tno++;
         end
         if (ld) begin
            e_data = m_word[7:0];
            if (nine_bit) e_b9 = m_word[8];
            e_done = 1;
         end else if (clr_done) e_done = 0;
         if (sf) e_fe = 1;
         else if (clr_fe) e_fe = 0;
         m_prev = m_line; m_line = m_s1; m_s1 = rx_line;
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !ended) begin
         n_vec++;
         if (rx_data !== e_data) begin
            n_bad++; $display("FAIL R4 data: actual %h expected %h at %0t", rx_data, e_data, $time);
         end
         if (rx_bit9 !== e_b9) begin
            n_bad++; $display("FAIL R5 bit9: actual %b expected %b at %0t", rx_bit9, e_b9, $time);
         end
         if (rx_done !== e_done) begin  // completion point also covers R1, R2 timing
            n_bad++; $display("FAIL R1 done timing: actual %b expected %b at %0t", rx_done, e_done, $time);
         end
         if (rx_ferr !== e_fe) begin
            n_bad++; $display("FAIL R7 ferr: actual %b expected %b at %0t", rx_ferr, e_fe, $time);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   initial begin
      forever begin
         repeat (3) @(negedge clk);
         os_tick = 1'b1;
         @(negedge clk);
         os_tick = 1'b0;
      end
   end

   task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      rx_line = 1'b1;
      repeat (n) @(negedge clk);
   endtask

   // glitch_pos: bit index (0 = start) that receives a 4-clock low pulse, -1 none
   task automatic send_frame(input logic [7:0] d, input logic use9, input logic b9,
                             input logic stopv, input int glitch_pos);
      logic [10:0] bits;
      int nbits;
      bits  = {stopv, b9, d, 1'b0};
      nbits = use9 ? 11 : 10;
      if (!use9) bits[9] = stopv;
      for (int i = 0; i < nbits; i++) begin
         if (i == glitch_pos) begin
            rx_line = bits[i]; repeat (28) @(negedge clk);
            rx_line = 1'b0;    repeat (4)  @(negedge clk);
            rx_line = bits[i]; repeat (BITCLK - 32) @(negedge clk);
         end else begin
            rx_line = bits[i];
            repeat (BITCLK) @(negedge clk);
         end
      end
      idle(BITCLK);
   endtask

   task automatic pulse(ref logic sig);
      sig = 1'b1; @(negedge clk); sig = 1'b0; @(negedge clk);
   endtask

   // ---------------- directed sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 data after reset", {1'b0, rx_data}, 9'h000);
      check("R11 flags after reset", {6'd0, rx_bit9, rx_done, rx_ferr}, 9'h000);

      rx_en = 1'b1;
      idle(40);
      send_frame(8'hA5, 0, 0, 1, -1);
      check("R4 byte lsb first", {1'b0, rx_data}, 9'h0A5);
      check("R6 done without check", {8'd0, rx_done}, 9'h001);
      idle(100);
      check("R9 done holds", {8'd0, rx_done}, 9'h001);
      pulse(clr_done);
      check("R9 done cleared", {8'd0, rx_done}, 9'h000);

      send_frame(8'h3C, 0, 0, 0, -1);
      check("R6 bad stop ignored", {7'd0, rx_done, rx_ferr}, 9'h002);
      check("R6 data", {1'b0, rx_data}, 9'h03C);
      pulse(clr_done);

      chk_en = 1'b1;
      send_frame(8'h5A, 0, 0, 1, -1);
      check("R7 good frame no error", {7'd0, rx_done, rx_ferr}, 9'h002);
      pulse(clr_done);
      send_frame(8'hC3, 0, 0, 0, -1);
      check("R7 bad stop flagged", {7'd0, rx_done, rx_ferr}, 9'h003);
      check("R7 data with bad stop", {1'b0, rx_data}, 9'h0C3);
      pulse(clr_done);
      send_frame(8'h81, 0, 0, 1, -1);
      check("R8 error survives good frame", {8'd0, rx_ferr}, 9'h001);
      pulse(clr_fe);
      check("R8 error cleared", {8'd0, rx_ferr}, 9'h000);
      pulse(clr_done);

      nine_bit = 1'b1;
      send_frame(8'h96, 1, 1, 1, -1);
      check("R5 ninth bit one", {rx_bit9, rx_data}, 9'h196);
      pulse(clr_done);
      chk_en = 1'b0;
      send_frame(8'h69, 1, 0, 1, -1);
      check("R5 ninth bit zero", {rx_bit9, rx_data}, 9'h069);
      send_frame(8'hF0, 1, 1, 1, -1);
      pulse(clr_done);
      nine_bit = 1'b0;
      send_frame(8'h0F, 0, 0, 1, -1);
      check("R5 ninth kept in 8-bit mode", {rx_bit9, rx_data}, 9'h10F);
      pulse(clr_done);

      // false start: one-strobe low pulse
      rx_line = 1'b0; repeat (4) @(negedge clk);
      idle(3 * BITCLK);
      check("R3 false start ignored", {rx_done, rx_data}, 9'h00F);
      send_frame(8'h42, 0, 0, 1, -1);
      check("R3 receive after false start", {rx_done, rx_data}, 9'h142);
      pulse(clr_done);

      send_frame(8'h5A, 0, 0, 1, 4);
      check("R2 single disturbed sample", {rx_done, rx_data}, 9'h15A);
      pulse(clr_done);

      // disable in the middle of a frame
      rx_line = 1'b0; repeat (BITCLK) @(negedge clk);
      rx_line = 1'b1; repeat (2 * BITCLK) @(negedge clk);
      rx_en = 1'b0;
      rx_line = 1'b0; repeat (4 * BITCLK) @(negedge clk);
      idle(3 * BITCLK);
      rx_en = 1'b1;
      idle(BITCLK);
      check("R10 dropped frame", {rx_done, rx_data}, 9'h05A);

      // clear held through a completion: set wins on the load clock only
      clr_done = 1'b1;
      send_frame(8'h24, 0, 0, 1, -1);
      clr_done = 1'b0;
      check("R9 clear after set", {rx_done, rx_data}, 9'h024);
      chk_en = 1'b1;
      send_frame(8'hE7, 0, 0, 1, -1);
      check("R1 full frame", {rx_done, rx_data}, 9'h1E7);

      idle(20);
      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule